// File: doc/BRIEF.md
# Register Poll Unit with Bounded Retry

This block carries out the poll instruction for a display command executor. Before the instruction, the executor writes two configuration words: a compare mask, and a poll function word that holds an enable flag, a wait interval counted in microseconds and an attempt count. When a poll request arrives with a register offset and an expected value, the unit reads the target register through a simple request/acknowledge read port. It compares the masked read value against the masked expected value. If they differ, it waits out the interval and reads again.

A match ends the poll with a one-cycle done pulse. If every attempt fails, the unit raises done together with an error flag and sets a sticky poll-error status bit. That status bit, gated by its own enable bit, drives the interrupt output. The status bit is cleared by writing a one to it. The microsecond time base is derived from the clock through the parameter `CLKS_PER_US`.

The executor is expected to leave five no-op slots between the configuration writes and the poll instruction. For that reason the unit samples the mask, the interval and the count only once, when it accepts the request.

Top module: `reg_poll_unit`

## Requirements
- R1: After reset, `busy`, `rd_req`, `done`, `done_err` and `irq` are all low.
- R2: If a poll is requested while the enable field (function word bit 31) is clear, `done` pulses in the next cycle with `done_err` low, and no read is issued.
- R3: While a poll is enabled and running, each read presents the requested offset on `rd_addr` and keeps `rd_req` and `rd_addr` steady until `rd_ack`. The first read is requested in the cycle after the request is accepted.
- R4: A read counts as a hit when `(rd_data & mask) == (expected & mask)`. On a hit, `done` pulses with `done_err` low in the cycle after the acknowledged read. A mask of zero therefore hits on the first read.
- R5: After a miss with attempts remaining, `rd_req` rises again exactly `W*CLKS_PER_US + 1` cycles after the acknowledge cycle. W is the wait field at function word bits [16 +: WAIT_W], and W = 0 means the read is retried at once.
- R6: The count field (function word bits [0 +: CNT_W]) sets the total number of reads made without a hit. A count of zero behaves as one.
- R7: When the last attempt misses, `done` and `done_err` pulse together in the cycle after the acknowledge, and the poll-error status bit is set.
- R8: `irq` equals the status bit ANDed with the interrupt enable bit (select 3, bit 0). Writing 1 to bit 0 at select 2 clears the status bit; writing 0 leaves it set.
- R9: If an error sets the status bit in the same cycle that software writes to clear it, the status bit ends up set.
- R10: The mask, wait and count are sampled when the request is accepted. Configuration writes made while a poll runs do not change that poll.
- R11: A request that arrives while `busy` is high is ignored: it causes no second done and no change of the read offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Select: 0 mask, 1 function word, 2 status (write 1 to clear), 3 interrupt enable |
| cfg_wdata | input | DATA_W | Configuration write data |
| req_valid | input | 1 | Poll request, one cycle |
| req_offset | input | OFF_W | Register offset to poll |
| req_expected | input | DATA_W | Expected register value |
| busy | output | 1 | Poll in progress |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | OFF_W | Read offset |
| rd_ack | input | 1 | Read acknowledge, with data valid |
| rd_data | input | DATA_W | Read data |
| done | output | 1 | Poll finished, one-cycle pulse |
| done_err | output | 1 | Poll finished without a hit |
| irq | output | 1 | Poll-error interrupt |

## Verification
The main sweep crosses attempt counts 0 to 5 with wait intervals 0 to 2 µs. For each pair, the hit is placed on every possible attempt, and there is also a run that never hits. This separates off-by-one faults in the attempt counter, in the zero-count rule and in the retry spacing. Miss data flips the lowest masked bit, and hit data flips every unmasked bit, so a compare that ignores the mask or inverts it fails at once. Directed runs cover a zero mask, a disabled poll, a clear that collides with the error set, and configuration rewrites and extra requests during a poll.

// File: rtl/reg_poll_pkg.sv
package reg_poll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WAIT = 2'd2
  } poll_state_e;

  localparam logic [1:0] SEL_MASK = 2'd0;
  localparam logic [1:0] SEL_FUNC = 2'd1;
  localparam logic [1:0] SEL_STS  = 2'd2;
  localparam logic [1:0] SEL_IEN  = 2'd3;

  localparam int FN_EN_BIT   = 31;
  localparam int FN_WAIT_LSB = 16;
  localparam int FN_CNT_LSB  = 0;
endpackage

// File: rtl/rpoll_cfg_regs.sv
module rpoll_cfg_regs
  import reg_poll_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WAIT_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              err_set,
  output logic [DATA_W-1:0] mask_o,
  output logic              en_o,
  output logic [WAIT_W-1:0] wait_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              sts_o,
  output logic              ien_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] mask_q, mask_d;
  logic              en_q, en_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              sts_q, sts_d;
  logic              ien_q, ien_d;
  logic              cfg_ce;

  always_comb begin
    mask_d = mask_q;
    en_d   = en_q;
    wait_d = wait_q;
    cnt_d  = cnt_q;
    sts_d  = sts_q;
    ien_d  = ien_q;
    if (we) begin
      unique case (sel)
        SEL_MASK: mask_d = wdata;
        SEL_FUNC: begin
          en_d   = wdata[FN_EN_BIT];
          wait_d = wdata[FN_WAIT_LSB +: WAIT_W];
          cnt_d  = wdata[FN_CNT_LSB +: CNT_W];
        end
        SEL_STS:  if (wdata[0]) sts_d = 1'b0;
        SEL_IEN:  ien_d = wdata[0];
        default:  ;
      endcase
    end
    if (err_set) sts_d = 1'b1;
  end

  assign cfg_ce = we | err_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      en_q   <= 1'b0;
      wait_q <= '0;
      cnt_q  <= '0;
      sts_q  <= 1'b0;
      ien_q  <= 1'b0;
    end else if (cfg_ce) begin
      mask_q <= mask_d;
      en_q   <= en_d;
      wait_q <= wait_d;
      cnt_q  <= cnt_d;
      sts_q  <= sts_d;
      ien_q  <= ien_d;
    end
  end

  assign mask_o = mask_q;
  assign en_o   = en_q;
  assign wait_o = wait_q;
  assign cnt_o  = cnt_q;
  assign sts_o  = sts_q;
  assign ien_o  = ien_q;
  assign irq_o  = sts_q & ien_q;
endmodule

// File: rtl/rpoll_interval_timer.sv
module rpoll_interval_timer #(
  parameter int CLKS_PER_US = 250,
  parameter int WAIT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic [WAIT_W-1:0] wait_us,
  output logic              expire
);
  localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [WAIT_W-1:0] us_q, us_d;
  logic              us_tick;
  logic              tmr_ce;

  assign us_tick = (pre_q == PRE_LAST);
  assign expire  = run && us_tick && (us_q == WAIT_W'(wait_us - 1'b1));
  assign tmr_ce  = clear | run;

  always_comb begin
    pre_d = pre_q;
    us_d  = us_q;
    if (clear) begin
      pre_d = '0;
      us_d  = '0;
    end else if (run) begin
      if (us_tick) begin
        pre_d = '0;
        us_d  = us_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (tmr_ce) begin
      pre_q <= pre_d;
      us_q  <= us_d;
    end
  end
endmodule

// File: rtl/rpoll_ctrl.sv
module rpoll_ctrl
  import reg_poll_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 20,
  parameter int WAIT_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_expected,
  input  logic [DATA_W-1:0] cfg_mask,
  input  logic              cfg_en,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              tmr_expire,
  output logic              tmr_clear,
  output logic              tmr_run,
  output logic [WAIT_W-1:0] tmr_wait,
  output logic              rd_req,
  output logic [OFF_W-1:0]  rd_addr,
  output logic              busy,
  output logic              done,
  output logic              done_err,
  output logic              err_set
);
  poll_state_e       state_q, state_d;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] exp_q, mask_q;
  logic [WAIT_W-1:0] wait_q;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              done_q, done_d, err_q, err_d;
  logic              cap_en, left_ce, hit;

  assign hit     = ((rd_data & mask_q) == (exp_q & mask_q));
  assign cap_en  = (state_q == ST_IDLE) && req_valid && cfg_en;
  assign left_ce = cap_en || ((state_q == ST_READ) && rd_ack);

  always_comb begin
    state_d   = state_q;
    left_d    = left_q;
    done_d    = 1'b0;
    err_d     = 1'b0;
    err_set   = 1'b0;
    tmr_clear = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (!cfg_en) begin
            done_d = 1'b1;
          end else begin
            left_d  = (cfg_cnt == '0) ? CNT_W'(1) : cfg_cnt;
            state_d = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (rd_ack) begin
          if (hit) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else if (left_q == CNT_W'(1)) begin
            done_d  = 1'b1;
            err_d   = 1'b1;
            err_set = 1'b1;
            state_d = ST_IDLE;
          end else begin
            left_d    = left_q - 1'b1;
            tmr_clear = 1'b1;
            state_d   = (wait_q == '0) ? ST_READ : ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (tmr_expire) state_d = ST_READ;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      exp_q  <= '0;
      mask_q <= '0;
      wait_q <= '0;
    end else if (cap_en) begin
      off_q  <= req_offset;
      exp_q  <= req_expected;
      mask_q <= cfg_mask;
      wait_q <= cfg_wait;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (left_ce) begin
      left_q <= left_d;
    end
  end

  assign tmr_run  = (state_q == ST_WAIT);
  assign tmr_wait = wait_q;
  assign rd_req   = (state_q == ST_READ);
  assign rd_addr  = off_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign done_err = err_q;
endmodule

// File: rtl/reg_poll_unit.sv
module reg_poll_unit #(
  parameter int DATA_W      = 32,
  parameter int OFF_W       = 20,
  parameter int WAIT_W      = 8,
  parameter int CNT_W       = 8,
  parameter int CLKS_PER_US = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_expected,
  output logic              busy,
  output logic              rd_req,
  output logic [OFF_W-1:0]  rd_addr,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              done_err,
  output logic              irq
);
  logic [DATA_W-1:0] cfg_mask;
  logic              cfg_en;
  logic [WAIT_W-1:0] cfg_wait;
  logic [CNT_W-1:0]  cfg_cnt;
  logic              sts_bit, ien_bit, err_set;
  logic              tmr_clear, tmr_run, tmr_expire;
  logic [WAIT_W-1:0] tmr_wait;

  rpoll_cfg_regs #(
    .DATA_W(DATA_W), .WAIT_W(WAIT_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_addr), .wdata(cfg_wdata),
    .err_set(err_set), .mask_o(cfg_mask), .en_o(cfg_en), .wait_o(cfg_wait),
    .cnt_o(cfg_cnt), .sts_o(sts_bit), .ien_o(ien_bit), .irq_o(irq)
  );

  rpoll_interval_timer #(
    .CLKS_PER_US(CLKS_PER_US), .WAIT_W(WAIT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .run(tmr_run),
    .wait_us(tmr_wait), .expire(tmr_expire)
  );

  rpoll_ctrl #(
    .DATA_W(DATA_W), .OFF_W(OFF_W), .WAIT_W(WAIT_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
    .req_expected(req_expected), .cfg_mask(cfg_mask), .cfg_en(cfg_en),
    .cfg_wait(cfg_wait), .cfg_cnt(cfg_cnt), .rd_ack(rd_ack), .rd_data(rd_data),
    .tmr_expire(tmr_expire), .tmr_clear(tmr_clear), .tmr_run(tmr_run),
    .tmr_wait(tmr_wait), .rd_req(rd_req), .rd_addr(rd_addr), .busy(busy),
    .done(done), .done_err(done_err), .err_set(err_set)
  );
endmodule

// File: rtl/reg_poll_unit_chk.sv
module reg_poll_unit_chk #(
  parameter int OFF_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             rd_req,
  input logic             rd_ack,
  input logic [OFF_W-1:0] rd_addr,
  input logic             done,
  input logic             done_err,
  input logic             sts,
  input logic             err_set,
  input logic             cfg_we,
  input logic [1:0]       cfg_addr,
  input logic             clr_bit
);
  // R3: an unacknowledged read stays requested at the same offset
  a_r3_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  // R4: completion follows either an acknowledged read or an idle request
  a_r4_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rd_ack) || !$past(busy));

  // R7: an error completion is also a completion, and leaves the status set
  a_r7_err_is_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done && sts);

  // R7: errors only come from a failed read
  a_r7_err_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> $past(rd_ack));

  // R9: the error set wins over a same-cycle clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> sts);

  // R8: status is sticky unless a one is written to it
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sts && !(cfg_we && cfg_addr == 2'd2 && clr_bit) |=> sts);

  // R11: no completion while a read is still outstanding
  a_r11_no_done_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !done);
endmodule

bind reg_poll_unit reg_poll_unit_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_req(rd_req), .rd_ack(rd_ack),
  .rd_addr(rd_addr), .done(done), .done_err(done_err), .sts(sts_bit),
  .err_set(err_set), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .clr_bit(cfg_wdata[0])
);

// File: tb/reg_poll_unit_tb_top.sv
`timescale 1ns/1ps
module reg_poll_unit_tb_top;
  localparam int DW = 32, OW = 20, WW = 4, CW = 4, CPU = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic [OW-1:0] req_offset = '0;
  logic [DW-1:0] req_expected = '0;
  logic          rd_ack = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic          busy, rd_req, done, done_err, irq;
  logic [OW-1:0] rd_addr;

  reg_poll_unit #(.DATA_W(DW), .OFF_W(OW), .WAIT_W(WW), .CNT_W(CW), .CLKS_PER_US(CPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_offset(req_offset), .req_expected(req_expected),
    .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .done(done), .done_err(done_err), .irq(irq)
  );

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // monitor and read responder state
  int reads = 0, last_ack = 0, done_cnt = 0, done_cyc = 0, first_req = -1;
  int exp_gap = 1, match_at = 1, clr_at = -1;
  bit done_e = 0, prev_req = 0, clr_pend = 0;
  logic [DW-1:0] cur_exp = '0, cur_mask = '0;
  logic [OW-1:0] cur_off = '0;

  always @(negedge clk) begin
    if (rd_req && (!prev_req || rd_ack)) begin
      if (reads > 0) chk(cyc - last_ack == exp_gap, "R5 retry spacing", cyc - last_ack, exp_gap);
      else if (first_req < 0) first_req = cyc;
    end
    if (done) begin
      done_cnt++;
      done_cyc = cyc;
      done_e = done_err;
    end
    prev_req = rd_req;
    if (clr_pend) begin
      cfg_we = 1'b0;
      clr_pend = 0;
    end
    if (rd_ack) begin
      rd_ack = 1'b0;
    end else if (rd_req) begin
      reads++;
      last_ack = cyc;
      chk(rd_addr == cur_off, "R3 read offset", rd_addr, cur_off);
      rd_data = (reads == match_at) ? (cur_exp ^ ~cur_mask)
                                    : (cur_exp ^ (cur_mask & (~cur_mask + 1'b1)));
      rd_ack = 1'b1;
      if (clr_at == reads) begin
        cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 32'h1; clr_pend = 1;
      end
    end
  end

  task automatic cfg_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [DW-1:0] fn_word(input bit en, input int w, input int c);
    return (DW'(en) << 31) | (DW'(w) << 16) | DW'(c);
  endfunction

  int issue_cyc = 0;
  task automatic issue(input logic [OW-1:0] off, input logic [DW-1:0] e);
    @(negedge clk);
    req_valid = 1'b1; req_offset = off; req_expected = e; issue_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic clear_mon();
    reads = 0; done_cnt = 0; done_e = 0; first_req = -1;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (done_cnt == 0 && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(done_cnt != 0, req, done_cnt, 1);
    repeat (3) @(negedge clk);
  endtask

  // R4 R5 R6 R7: one poll with the given configuration
  task automatic run_case(input logic [DW-1:0] m, input int cnt, input int w, input int hit_at,
                          input logic [OW-1:0] off, input logic [DW-1:0] e);
    int eff, xreads;
    bit xerr;
    cfg_write(2'd0, m);
    cfg_write(2'd1, fn_word(1, w, cnt));
    cur_mask = m; cur_exp = e; cur_off = off; match_at = hit_at; exp_gap = w * CPU + 1;
    eff = (cnt == 0) ? 1 : cnt;
    if (m == '0) begin xreads = 1; xerr = 0; end
    else begin
      xreads = (hit_at <= eff) ? hit_at : eff;
      xerr = (hit_at > eff);
    end
    clear_mon();
    issue(off, e);
    wait_done("R4 completion seen");
    chk(first_req == issue_cyc + 1, "R3 first read timing", first_req, issue_cyc + 1);
    chk(reads == xreads, "R6 read attempts", reads, xreads);
    chk(done_cnt == 1, "R4 single done", done_cnt, 1);
    chk(done_e == xerr, "R7 error flag", done_e, xerr);
    chk(done_cyc == last_ack + 1, "R4 done timing", done_cyc, last_ack + 1);
    chk(irq == xerr, "R8 irq after poll", irq, xerr);
    if (xerr) begin
      cfg_write(2'd2, 32'h1);
      chk(irq == 1'b0, "R8 status cleared", irq, 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, rd_req, done, done_err, irq} == 5'b0, "R1 in reset", {busy, rd_req, done, done_err, irq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, rd_req, done, done_err, irq} == 5'b0, "R1 after reset", {busy, rd_req, done, done_err, irq}, 0);

    // R2 disabled poll
    cfg_write(2'd3, 32'h1);
    cfg_write(2'd0, 32'hFFFF_FFFF);
    cfg_write(2'd1, fn_word(0, 2, 3));
    cur_off = 20'h0;
    clear_mon();
    issue(20'h123, 32'hDEAD_BEEF);
    wait_done("R2 completion seen");
    chk(done_cyc == issue_cyc + 1, "R2 done timing", done_cyc, issue_cyc + 1);
    chk(reads == 0, "R2 no read", reads, 0);
    chk(done_e == 0, "R2 no error", done_e, 0);
    chk(irq == 0, "R2 no irq", irq, 0);

    // main sweep: count x wait x hit position
    for (int c = 0; c <= 5; c++)
      for (int w = 0; w <= 2; w++) begin
        int eff = (c == 0) ? 1 : c;
        for (int h = 1; h <= eff + 1; h++)
          run_case(32'h0000_FF00, c, w, h, OW'(c * 4099 + w * 257 + h), 32'h1234_5600 + DW'(h));
      end

    // R4 zero mask hits at once
    run_case(32'h0, 3, 1, 99, 20'hABCDE, 32'h5555_AAAA);

    // R8 enable gating and write-zero has no effect
    run_case(32'hF, 1, 0, 9, 20'h00042, 32'h0);
    cfg_write(2'd0, 32'hF);
    cfg_write(2'd1, fn_word(1, 0, 1));
    cur_mask = 32'hF; cur_exp = 32'h7; cur_off = 20'h77; match_at = 9;
    clear_mon();
    issue(20'h77, 32'h7);
    wait_done("R7 completion seen");
    chk(irq == 1, "R7 irq raised", irq, 1);
    cfg_write(2'd2, 32'h0);
    chk(irq == 1, "R8 write zero keeps status", irq, 1);
    cfg_write(2'd3, 32'h0);
    chk(irq == 0, "R8 enable off masks irq", irq, 0);
    cfg_write(2'd3, 32'h1);
    chk(irq == 1, "R8 enable on shows status", irq, 1);
    cfg_write(2'd2, 32'h1);
    chk(irq == 0, "R8 clear", irq, 0);

    // R9 clear collides with error set
    cfg_write(2'd1, fn_word(1, 0, 1));
    clear_mon();
    clr_at = 1;
    issue(20'h77, 32'h7);
    wait_done("R9 completion seen");
    clr_at = -1;
    chk(done_e == 1, "R9 error", done_e, 1);
    chk(irq == 1, "R9 set wins", irq, 1);
    cfg_write(2'd2, 32'h1);

    // R10 R11 snapshot and busy request ignored
    cfg_write(2'd0, 32'hF0);
    cfg_write(2'd1, fn_word(1, 2, 3));
    cur_mask = 32'hF0; cur_exp = 32'h30; cur_off = 20'h0AB; match_at = 9; exp_gap = 2 * CPU + 1;
    clear_mon();
    issue(20'h0AB, 32'h30);
    repeat (2) @(negedge clk);
    cfg_write(2'd1, fn_word(1, 0, 7));
    cfg_write(2'd0, 32'h0);
    issue(20'h0CD, 32'h0);
    wait_done("R10 completion seen");
    chk(reads == 3, "R10 count snapshot", reads, 3);
    chk(done_e == 1, "R10 mask snapshot", done_e, 1);
    chk(done_cnt == 1, "R11 busy request ignored", done_cnt, 1);
    chk(busy == 0, "R11 idle afterwards", busy, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule